// File: doc/BRIEF.md
# Condition-Code Integer Divider

A multi-cycle integer divider for a processor execution unit. It takes a start strobe and a size mode: word divides a 32-bit dividend by a 16-bit divisor, long divides a 32-bit dividend by a 32-bit divisor, and quad divides a 64-bit dividend by a 32-bit divisor. A separate bit selects signed or unsigned. The block also receives the current values of the quotient register and the remainder register, the divisor, and a flag that says the two destination registers are the same one. It produces the data to write back, one write enable for each register, the N/Z/V/C condition flags, a done pulse and a divide-by-zero pulse.

A radix-2 restoring engine works on magnitudes and produces one quotient bit per cycle. A sign fix-up follows: the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. Overflow is detected against the width of the destination. When it occurs, the registers are left alone and the flags change in the architected way. The register file and the exception dispatch sit outside this block.

Top module: `cc_divider`

## Requirements
- R1: A start whose effective divisor is zero makes dz_o pulse for exactly one cycle after the start edge. done_o, busy_o and both write enables stay low, and the flags keep their values. In word mode the effective divisor is divisor_i[15:0] only.
- R2: flag_c_o is 0 after every completed division, including one that overflows.
- R3: Word mode (size_i=0). An unsigned quotient above 0xFFFF is an overflow. A signed quotient outside -32768..32767 is an overflow.
- R4: On overflow: done_o pulses, flag_v_o=1, flag_z_o=0, flag_n_o keeps its previous value, and neither write enable is raised.
- R5: A word result without overflow raises quo_we_o alone. quo_o holds the remainder in bits 31:16 and the quotient in bits 15:0. N is quotient bit 15, and Z is set when the 16-bit quotient is zero.
- R6: Quad mode (size_i=2) divides the 64-bit value {rem_reg_i, quo_reg_i}. It overflows when the quotient does not fit in 32 bits, unsigned or two's-complement as selected.
- R7: Long (size_i=1 or 3) and quad results without overflow raise quo_we_o with the 32-bit quotient. They raise rem_we_o with the remainder only when same_reg_i=0. With same_reg_i=1 only the quotient is written.
- R8: Without overflow, flag_v_o=0. In long and quad modes, N is quotient bit 31 and Z is set when the 32-bit quotient is zero.
- R9: Signed division truncates toward zero. The remainder has the dividend's sign, and the quotient is negative when the operand signs differ.
- R10: After an accepted start edge, busy_o is high for N+1 cycles and done_o pulses in the next cycle, with busy_o low. N is 32 in word and long modes and 64 in quad mode.
- R11: start_i is ignored while busy_o is high, even when its divisor is zero.
- R12: During and after reset, busy_o, done_o, dz_o, the write enables, the flags and the data outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; taken only when idle |
| size_i | input | 2 | 0 word, 1 long, 2 quad, 3 same as long |
| signed_i | input | 1 | Two's-complement operands when 1 |
| same_reg_i | input | 1 | Quotient and remainder registers are the same |
| quo_reg_i | input | 32 | Quotient register value; the dividend, or its low half in quad mode |
| rem_reg_i | input | 32 | Remainder register value; high half of the dividend in quad mode |
| divisor_i | input | 32 | Divisor; low 16 bits in word mode |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_o | output | 1 | One-cycle divide-by-zero pulse |
| quo_we_o | output | 1 | Write quo_o to the quotient register |
| rem_we_o | output | 1 | Write rem_o to the remainder register |
| quo_o | output | 32 | Quotient, or the packed remainder and quotient in word mode |
| rem_o | output | 32 | Remainder |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench builds the block with the default register width of 32, so the cycle counts are 33 and 65. At this width the exact overflow edges can be reached with 66-bit signed reference arithmetic: quotients of -32768 and +32768 in word mode, 2^31 unsigned against signed in quad mode, and the most negative dividend divided by -1. It also reaches a word divisor that is zero only in its low half, and a start carrying a zero divisor injected in the middle of a busy division.

// File: rtl/cc_div_pkg.sv
package cc_div_pkg;
  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_LONG = 2'd1,
    SZ_QUAD = 2'd2,
    SZ_ALT  = 2'd3
  } div_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;
endpackage

// File: rtl/cc_div_prep.sv
module cc_div_prep
  import cc_div_pkg::*;
#(
  parameter int W = 32,
  localparam int H = W / 2,
  localparam int CNT_W = $clog2(2 * W + 1)
) (
  input  div_size_e          size_i,
  input  logic               signed_i,
  input  logic [W-1:0]       quo_reg_i,
  input  logic [W-1:0]       rem_reg_i,
  input  logic [W-1:0]       divisor_i,
  output logic [2*W-1:0]     num_o,
  output logic [W-1:0]       den_o,
  output logic [CNT_W-1:0]   steps_o,
  output logic               den_zero_o,
  output logic               neg_q_o,
  output logic               neg_r_o
);
  logic [2*W-1:0] dvd_full, dvd_mag;
  logic [W-1:0]   den_ext;
  logic           dvd_neg, den_neg, quad;

  assign quad = (size_i == SZ_QUAD);

  always_comb begin
    if (quad)          dvd_full = {rem_reg_i, quo_reg_i};
    else if (signed_i) dvd_full = {{W{quo_reg_i[W-1]}}, quo_reg_i};
    else               dvd_full = {{W{1'b0}}, quo_reg_i};
  end

  always_comb begin
    if (size_i == SZ_WORD)
      den_ext = signed_i ? {{(W-H){divisor_i[H-1]}}, divisor_i[H-1:0]}
                         : {{(W-H){1'b0}}, divisor_i[H-1:0]};
    else
      den_ext = divisor_i;
  end

  assign dvd_neg = signed_i & dvd_full[2*W-1];
  assign den_neg = signed_i & den_ext[W-1];
  assign dvd_mag = dvd_neg ? -dvd_full : dvd_full;
  assign den_o   = den_neg ? -den_ext : den_ext;

  // narrow dividends sit in the upper half so W steps leave the quotient low
  assign num_o      = quad ? dvd_mag : {dvd_mag[W-1:0], {W{1'b0}}};
  assign steps_o    = quad ? CNT_W'(2 * W) : CNT_W'(W);
  assign den_zero_o = (den_ext == '0);
  assign neg_q_o    = dvd_neg ^ den_neg;
  assign neg_r_o    = dvd_neg;
endmodule

// File: rtl/cc_div_core.sv
module cc_div_core
  import cc_div_pkg::*;
#(
  parameter int W = 32,
  localparam int CNT_W = $clog2(2 * W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2*W-1:0]   num_i,
  input  logic [W-1:0]     den_i,
  input  logic [CNT_W-1:0] steps_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [2*W-1:0]   q_o,
  output logic [W-1:0]     r_o
);
  div_state_e       state;
  logic [2*W-1:0]   acc;
  logic [W-1:0]     rem, den_q, rem_nx;
  logic [W:0]       trial;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign trial  = {rem, acc[2*W-1]};
  assign take   = (trial >= {1'b0, den_q});
  assign rem_nx = take ? (trial[W-1:0] - den_q) : trial[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      acc   <= '0;
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load_i) begin
          acc   <= num_i;
          den_q <= den_i;
          rem   <= '0;
          cnt   <= steps_i;
          state <= ST_RUN;
        end
        ST_RUN: begin
          rem <= rem_nx;
          acc <= {acc[2*W-2:0], take};
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign fin_o  = (state == ST_FIN);
  assign q_o    = acc;
  assign r_o    = rem;

  p_load_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> state == ST_IDLE);
  p_run_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN && cnt != CNT_W'(1)) |=> state == ST_RUN);
  p_rem_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RUN) |=> rem < den_q);
endmodule

// File: rtl/cc_div_result.sv
module cc_div_result
  import cc_div_pkg::*;
#(
  parameter int W = 32,
  localparam int H = W / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           dz_i,
  input  div_size_e      size_i,
  input  logic           signed_i,
  input  logic           same_reg_i,
  input  logic           neg_q_i,
  input  logic           neg_r_i,
  input  logic           fin_i,
  input  logic [2*W-1:0] q_mag_i,
  input  logic [W-1:0]   r_mag_i,
  output logic           done_o,
  output logic           dz_o,
  output logic           quo_we_o,
  output logic           rem_we_o,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           flag_n_o,
  output logic           flag_z_o,
  output logic           flag_v_o,
  output logic           flag_c_o
);
  localparam logic [2*W-1:0] HALF_UMAX = {{(2*W-H){1'b0}}, {H{1'b1}}};
  localparam logic [2*W-1:0] HALF_SMAX = HALF_UMAX >> 1;
  localparam logic [2*W-1:0] HALF_SNEG = HALF_SMAX + 1'b1;
  localparam logic [2*W-1:0] FULL_UMAX = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [2*W-1:0] FULL_SMAX = FULL_UMAX >> 1;
  localparam logic [2*W-1:0] FULL_SNEG = FULL_SMAX + 1'b1;

  div_size_e    size_q;
  logic         sgn_q, same_q, negq_q, negr_q;
  logic         word, ovf;
  logic [W-1:0] q_res, r_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= SZ_WORD;
      sgn_q  <= 1'b0;
      same_q <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (load_i) begin
      size_q <= size_i;
      sgn_q  <= signed_i;
      same_q <= same_reg_i;
      negq_q <= neg_q_i;
      negr_q <= neg_r_i;
    end
  end

  assign word = (size_q == SZ_WORD);

  always_comb begin
    if (word)
      ovf = sgn_q ? (q_mag_i > (negq_q ? HALF_SNEG : HALF_SMAX)) : (q_mag_i > HALF_UMAX);
    else
      ovf = sgn_q ? (q_mag_i > (negq_q ? FULL_SNEG : FULL_SMAX)) : (q_mag_i > FULL_UMAX);
  end

  assign q_res = negq_q ? -q_mag_i[W-1:0] : q_mag_i[W-1:0];
  assign r_res = negr_q ? -r_mag_i : r_mag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      dz_o     <= 1'b0;
      quo_we_o <= 1'b0;
      rem_we_o <= 1'b0;
      quo_o    <= '0;
      rem_o    <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_v_o <= 1'b0;
      flag_c_o <= 1'b0;
    end else begin
      done_o   <= fin_i;
      dz_o     <= dz_i;
      quo_we_o <= 1'b0;
      rem_we_o <= 1'b0;
      if (fin_i) begin
        flag_c_o <= 1'b0;
        if (ovf) begin
          flag_v_o <= 1'b1;
          flag_z_o <= 1'b0;
        end else begin
          flag_v_o <= 1'b0;
          quo_we_o <= 1'b1;
          rem_o    <= r_res;
          if (word) begin
            quo_o    <= {r_res[H-1:0], q_res[H-1:0]};
            flag_n_o <= q_res[H-1];
            flag_z_o <= (q_res[H-1:0] == '0);
          end else begin
            quo_o    <= q_res;
            rem_we_o <= ~same_q;
            flag_n_o <= q_res[W-1];
            flag_z_o <= (q_res == '0);
          end
        end
      end
    end
  end

  p_dz_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> (!done_o && !quo_we_o && !rem_we_o));
  p_dz_flags_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));
  p_carry_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !flag_c_o);
  p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_v_o) |-> (!quo_we_o && !rem_we_o && !flag_z_o
                              && flag_n_o == $past(flag_n_o)));
  p_word_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && word) |-> !rem_we_o);
  p_same_reg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && same_q) |-> !rem_we_o);
  p_we_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quo_we_o || rem_we_o) |-> done_o);
endmodule

// File: rtl/cc_divider.sv
module cc_divider
  import cc_div_pkg::*;
#(
  parameter int W = 32,
  localparam int CNT_W = $clog2(2 * W + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   size_i,
  input  logic         signed_i,
  input  logic         same_reg_i,
  input  logic [W-1:0] quo_reg_i,
  input  logic [W-1:0] rem_reg_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dz_o,
  output logic         quo_we_o,
  output logic         rem_we_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_v_o,
  output logic         flag_c_o
);
  div_size_e        size;
  logic [2*W-1:0]   num, q_mag;
  logic [W-1:0]     den, r_mag;
  logic [CNT_W-1:0] steps;
  logic             den_zero, neg_q, neg_r, accept, load, dz, fin;

  assign size   = div_size_e'(size_i);
  assign accept = start_i & ~busy_o;
  assign load   = accept & ~den_zero;
  assign dz     = accept & den_zero;

  cc_div_prep #(.W(W)) u_prep (
    .size_i     (size),
    .signed_i   (signed_i),
    .quo_reg_i  (quo_reg_i),
    .rem_reg_i  (rem_reg_i),
    .divisor_i  (divisor_i),
    .num_o      (num),
    .den_o      (den),
    .steps_o    (steps),
    .den_zero_o (den_zero),
    .neg_q_o    (neg_q),
    .neg_r_o    (neg_r)
  );

  cc_div_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .num_i   (num),
    .den_i   (den),
    .steps_i (steps),
    .busy_o  (busy_o),
    .fin_o   (fin),
    .q_o     (q_mag),
    .r_o     (r_mag)
  );

  cc_div_result #(.W(W)) u_result (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .dz_i       (dz),
    .size_i     (size),
    .signed_i   (signed_i),
    .same_reg_i (same_reg_i),
    .neg_q_i    (neg_q),
    .neg_r_i    (neg_r),
    .fin_i      (fin),
    .q_mag_i    (q_mag),
    .r_mag_i    (r_mag),
    .done_o     (done_o),
    .dz_o       (dz_o),
    .quo_we_o   (quo_we_o),
    .rem_we_o   (rem_we_o),
    .quo_o      (quo_o),
    .rem_o      (rem_o),
    .flag_n_o   (flag_n_o),
    .flag_z_o   (flag_z_o),
    .flag_v_o   (flag_v_o),
    .flag_c_o   (flag_c_o)
  );

  p_busy_dz_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_o |-> !busy_o);
  p_pulse_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, dz_o}));
endmodule

// File: tb/cc_divider_tb.sv
module cc_divider_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   size = 2'd0;
  logic         sgn = 1'b0;
  logic         same = 1'b0;
  logic [W-1:0] qreg = '0, rreg = '0, dv = '0;
  logic         busy, done, dz, quo_we, rem_we;
  logic [W-1:0] quo, rem;
  logic         fn, fz, fv, fc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // model state of the flags
  logic m_n = 0, m_z = 0, m_v = 0, m_c = 0;

  always #2 clk = ~clk;

  cc_divider #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size),
    .signed_i(sgn), .same_reg_i(same), .quo_reg_i(qreg), .rem_reg_i(rreg),
    .divisor_i(dv), .busy_o(busy), .done_o(done), .dz_o(dz),
    .quo_we_o(quo_we), .rem_we_o(rem_we), .quo_o(quo), .rem_o(rem),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 200000 cycles", cyc);
      finish_run();
    end
  end

  task automatic cmp_ctl(string tag, logic eb, logic ed, logic ez, logic eqw, logic erw);
    chk(tag, "busy", busy, eb);
    chk(tag, "done", done, ed);
    chk(tag, "dz", dz, ez);
    chk(tag, "quo_we", quo_we, eqw);
    chk(tag, "rem_we", rem_we, erw);
  endtask

  task automatic cmp_flags(string tag);
    chk(tag, "flag_n", fn, m_n);
    chk(tag, "flag_z", fz, m_z);
    chk(tag, "flag_v", fv, m_v);
    chk(tag, "flag_c", fc, m_c);
  endtask

  task automatic run_op(string tag, logic [1:0] sz, logic s, logic sm,
                        logic [31:0] hi, logic [31:0] lo, logic [31:0] d, bit inject);
    logic signed [65:0] nd, dd, q, r;
    logic ovf, zero, eqw, erw, nn, nz;
    logic [31:0] eq, er;
    int n;
    zero = (sz == 2'd0) ? (d[15:0] == 16'h0) : (d == 32'h0);
    if (sz == 2'd2) nd = s ? {{2{hi[31]}}, hi, lo} : {2'b00, hi, lo};
    else            nd = s ? {{34{lo[31]}}, lo} : {34'b0, lo};
    if (sz == 2'd0) dd = s ? {{50{d[15]}}, d[15:0]} : {50'b0, d[15:0]};
    else            dd = s ? {{34{d[31]}}, d} : {34'b0, d};
    q = '0; r = '0; ovf = 0;
    if (!zero) begin
      q = nd / dd;
      r = nd % dd;
      if (sz == 2'd0) ovf = s ? (q < -66'sd32768 || q > 66'sd32767) : (q > 66'sd65535);
      else ovf = s ? (q < -66'sd2147483648 || q > 66'sd2147483647) : (q > 66'sd4294967295);
    end
    eqw = 0; erw = 0; eq = '0; er = r[31:0]; nn = m_n; nz = 0;
    if (!ovf) begin
      eqw = 1;
      if (sz == 2'd0) begin
        eq = {r[15:0], q[15:0]}; nn = q[15]; nz = (q[15:0] == 16'h0);
      end else begin
        eq = q[31:0]; nn = q[31]; nz = (q[31:0] == 32'h0); erw = !sm;
      end
    end

    @(negedge clk);
    start = 1'b1; size = sz; sgn = s; same = sm; rreg = hi; qreg = lo; dv = d;
    @(posedge clk); #1;
    start = 1'b0;
    if (zero) begin
      cmp_ctl(tag, 0, 0, 1, 0, 0);   // R1 pulse after start edge
      cmp_flags(tag);
      @(posedge clk); #1;
      cmp_ctl(tag, 0, 0, 0, 0, 0);   // R1 single-cycle pulse
      cmp_flags(tag);
      return;
    end
    n = (sz == 2'd2) ? 64 : 32;
    for (int k = 0; k <= n + 1; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      if (k == n + 1) begin
        m_c = 0;
        if (ovf) begin m_v = 1; m_z = 0; end
        else begin m_v = 0; m_n = nn; m_z = nz; end
        cmp_ctl(tag, 0, 1, 0, eqw, erw);
        if (eqw) chk(tag, "quo", quo, eq);
        if (erw) chk(tag, "rem", rem, er);
      end else begin
        cmp_ctl(tag, 1, 0, 0, 0, 0);  // R10 busy window
      end
      cmp_flags(tag);
      // R11: a zero-divisor start during busy must be ignored
      if (inject && k == 3) begin
        start = 1'b1; dv = 32'h0; qreg = 32'h5; size = 2'd1;
      end else if (inject && k == 4) begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    cmp_ctl("R12", 0, 0, 0, 0, 0);
    cmp_flags("R12");
    chk("R12", "quo", quo, 0);
    chk("R12", "rem", rem, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp_ctl("R12", 0, 0, 0, 0, 0);

    run_op("R5",  2'd0, 0, 0, 32'h0, 32'd100000, 32'd7, 0);           // 14285 r5
    run_op("R3",  2'd0, 0, 0, 32'h0, 32'h12345678, 32'd2, 0);         // unsigned word ovf
    run_op("R9",  2'd0, 1, 0, 32'h0, -32'sd100, 32'd7, 0);            // -14 r -2
    run_op("R3",  2'd0, 1, 0, 32'h0, -32'sd32768, 32'd1, 0);          // fits
    run_op("R3",  2'd0, 1, 0, 32'h0, 32'd32768, 32'h0000FFFF, 0);     // /-1 -> -32768 fits
    run_op("R4",  2'd0, 1, 0, 32'h0, 32'd32768, 32'd1, 0);            // ovf, N held
    run_op("R5",  2'd0, 0, 0, 32'h0, 32'd3, 32'd5, 0);                // Z=1
    run_op("R1",  2'd0, 0, 0, 32'h0, 32'd77, 32'h00010000, 0);        // low half zero
    run_op("R8",  2'd1, 0, 0, 32'h0, 32'hFFFFFFFF, 32'd3, 1);         // with R11 inject
    run_op("R7",  2'd1, 0, 1, 32'h0, 32'd1000, 32'd7, 0);             // same reg
    run_op("R9",  2'd1, 1, 0, 32'h0, -32'sd7, 32'd2, 0);              // -3 r -1
    run_op("R9",  2'd3, 1, 0, 32'h0, 32'd7, -32'sd2, 0);              // size 3 as long
    run_op("R4",  2'd1, 1, 0, 32'h0, 32'h80000000, 32'hFFFFFFFF, 0);  // min / -1
    run_op("R6",  2'd2, 0, 0, 32'h1, 32'h0, 32'd2, 0);                // 2^31 unsigned fits
    run_op("R6",  2'd2, 1, 0, 32'h1, 32'h0, 32'd2, 0);                // signed ovf
    run_op("R6",  2'd2, 0, 0, 32'h5, 32'h0, 32'd2, 0);                // unsigned ovf
    run_op("R6",  2'd2, 1, 0, 32'h80000000, 32'h0, 32'hFFFFFFFF, 0);  // min64 / -1
    run_op("R9",  2'd2, 1, 0, 32'hFFFFFFFF, 32'hFFFFFF00, 32'd16, 1); // -16 r0, R11
    run_op("R7",  2'd2, 0, 1, 32'h0, 32'd1001, 32'd10, 0);            // same reg quad
    run_op("R2",  2'd2, 1, 0, 32'hFFFFFFFF, 32'h80000001, 32'd3, 0);
    run_op("R1",  2'd2, 1, 0, 32'h1, 32'h2, 32'h0, 0);
    run_op("R8",  2'd1, 1, 0, 32'h0, -32'sd50, 32'd5, 0);             // N=1
    run_op("R4",  2'd0, 0, 0, 32'h0, 32'h00FF0000, 32'd1, 0);         // ovf keeps N=1
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule